// File: doc/BRIEF.md
# Two-Thirds Clock Divider Using Both Input Edges

This block turns an input clock into an output clock at two thirds of its frequency: three input periods yield two output pulses. An edge-counting divider that works on one edge alone can only reach integer ratios. This block reaches the ratio of 1.5 by working on both edges of the input.

A three-state counter runs on the rising edge and produces an early pulse, one input period wide, in every third cycle. A two-stage path delays that pulse by one and a half input periods: one rising-edge register, then one falling-edge register. This places a second pulse exactly between two early pulses. The two trains are merged by an OR into the true output, and by a NOR into the complement.

With a symmetric input, the output pulses are evenly spaced. With a lopsided input, the 2/3 ratio still holds, but the gaps between pulses alternate in length. A reset that is synchronous and active low clears every register. The output then stays low until the counter has run through a full cycle.

Top module: `clk_two_thirds_div`

## Requirements
- R1: While `rst_n` is low at the clock edges, `clk_out` is 0 from the first rising edge onward, and no later than the next falling edge it is 0 in both halves of every input period.
- R2: Count the rising edges of `clk_in` after `rst_n` is sampled high, starting at 1. `clk_out` stays 0 through input periods 1 and 2 and goes high at rising edge 3.
- R3: Over any window of 3N whole input periods after start-up, `clk_out` shows exactly 2N rising transitions.
- R4: Each high pulse on `clk_out` lasts exactly one input period.
- R5: With a 50% duty input, consecutive rising transitions of `clk_out` are 1.5 input periods apart, and the early and late pulse trains never overlap.
- R6: `clk_out_n` is always the complement of `clk_out`.
- R7: The counter steps through the codes 0, 1, 2 and back to 0, and the unused code 3 returns to 0. `clk_out` is high in rising-edge period k (k ≥ 3, k mod 3 = 0) and in the half-periods from the falling edge of period j to the falling edge of period j+1 (j ≥ 4, j mod 3 = 1).
- R8: With an asymmetric input duty cycle, the R7 edge placement and the 2-per-3 ratio of R3 still hold.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_in | input | 1 | Input clock; both edges are used |
| rst_n | input | 1 | Synchronous active-low reset, sampled on both edges |
| clk_out | output | 1 | Divided clock at 2/3 of the input frequency |
| clk_out_n | output | 1 | Complement of `clk_out` (NOR of the two trains) |

## Verification
The bench drives a symmetric 100 MHz input. This shows whether the late pulse sits exactly midway between early pulses, with 1.5-period spacing and one-period widths. It then drives a 30/70 duty input at the same period. Here the spacing becomes uneven by design, while the 2-per-3 count and the edge placement must remain. This separates a correct use of the falling edge from a design that only happens to work when both halves of the period are equal. A reset is also applied mid-run and released again, to confirm that start-up behaves the same from any point of the cycle and that no stale late pulse is left behind.

// File: rtl/clk23_pkg.sv
`timescale 1ns/1ps
// Package: shared encoding for the two-thirds divider.
// Assumes: the counter is 2 bits wide; code 2'b11 is never entered on purpose.
package clk23_pkg;
    localparam int unsigned PHASE_W = 2;

    typedef enum logic [PHASE_W-1:0] {
        PH_IDLE = 2'b00,
        PH_MID  = 2'b01,
        PH_LAST = 2'b10,
        PH_BAD  = 2'b11
    } div_phase_t;
endpackage

// File: rtl/clk23_div3.sv
`timescale 1ns/1ps
// Module: clk23_div3
// Rising-edge divide-by-three counter. It emits a registered pulse that is
// one input period wide in every third period.
// Assumes: rst_n is synchronous, active low, and stable around rising edges.
module clk23_div3
    import clk23_pkg::*;
(
    input  logic clk_in,
    input  logic rst_n,
    output logic early_pulse
);
    div_phase_t phase_q;

    // Advance the counter; the unused code falls back to idle.
    always_ff @(posedge clk_in) begin
        if (!rst_n) begin
            phase_q <= PH_IDLE;
        end else begin
            case (phase_q)
                PH_IDLE: phase_q <= PH_MID;
                PH_MID:  phase_q <= PH_LAST;
                default: phase_q <= PH_IDLE;
            endcase
        end
    end

    // Register the decoded last phase so the pulse is glitch free.
    always_ff @(posedge clk_in) begin
        if (!rst_n) early_pulse <= 1'b0;
        else        early_pulse <= (phase_q == PH_LAST);
    end

    // R7: the counter steps from idle to the middle phase.
    assert_step_idle_R7: assert property (@(posedge clk_in) disable iff (!rst_n)
        (phase_q == PH_IDLE) |=> (phase_q == PH_MID));

    // R7: the last phase and the unused code both go back to idle.
    assert_wrap_R7: assert property (@(posedge clk_in) disable iff (!rst_n)
        (phase_q == PH_LAST || phase_q == PH_BAD) |=> (phase_q == PH_IDLE));

    // R4: the early pulse is never wider than one period.
    assert_single_period_R4: assert property (@(posedge clk_in) disable iff (!rst_n)
        early_pulse |=> !early_pulse);
endmodule

// File: rtl/clk23_halfstep.sv
`timescale 1ns/1ps
// Module: clk23_halfstep
// Delays the early pulse by one and a half input periods. A rising-edge
// stage is followed by a falling-edge stage.
// Assumes: the input clock has both edges; rst_n is stable at both of them.
module clk23_halfstep (
    input  logic clk_in,
    input  logic rst_n,
    input  logic early_pulse,
    output logic late_pulse
);
    logic stage_q;

    // Full-period stage on the rising edge.
    always_ff @(posedge clk_in) begin
        if (!rst_n) stage_q <= 1'b0;
        else        stage_q <= early_pulse;
    end

    // Half-period stage on the falling edge.
    always_ff @(negedge clk_in) begin
        if (!rst_n) late_pulse <= 1'b0;
        else        late_pulse <= stage_q;
    end
endmodule

// File: rtl/clk23_merge.sv
`timescale 1ns/1ps
// Module: clk23_merge
// Joins the two pulse trains into the true output (OR) and the
// complement output (NOR).
// Assumes: the trains never overlap, so each output pulse maps to one source.
module clk23_merge (
    input  logic early_pulse,
    input  logic late_pulse,
    output logic merged,
    output logic merged_n
);
    // Combine the trains; the complement is formed as a NOR.
    always_comb begin
        merged   = early_pulse | late_pulse;
        merged_n = ~(early_pulse | late_pulse);
    end
endmodule

// File: rtl/clk_two_thirds_div.sv
`timescale 1ns/1ps
// Module: clk_two_thirds_div
// Top level of the two-thirds divider. Three input periods give two output
// pulses: an early train from the counter and a late train from the
// 1.5-period delay, merged at the output.
// Assumes: even output spacing needs a symmetric input; the ratio itself
// does not depend on the input duty cycle.
module clk_two_thirds_div (
    input  logic clk_in,
    input  logic rst_n,
    output logic clk_out,
    output logic clk_out_n
);
    logic early_pulse;
    logic late_pulse;

    clk23_div3 u_div3 (
        .clk_in      (clk_in),
        .rst_n       (rst_n),
        .early_pulse (early_pulse)
    );

    clk23_halfstep u_halfstep (
        .clk_in      (clk_in),
        .rst_n       (rst_n),
        .early_pulse (early_pulse),
        .late_pulse  (late_pulse)
    );

    clk23_merge u_merge (
        .early_pulse (early_pulse),
        .late_pulse  (late_pulse),
        .merged      (clk_out),
        .merged_n    (clk_out_n)
    );

    // R1: a reset seen at a rising edge clears the early train.
    assert_reset_clear_R1: assert property (@(posedge clk_in)
        !rst_n |=> !early_pulse);

    // R5: at a rising edge the late train is low whenever the early train is high.
    assert_no_overlap_R5: assert property (@(posedge clk_in) disable iff (!rst_n)
        early_pulse |-> !late_pulse);

    // R5: a late pulse only starts while the early train is low.
    assert_late_start_R5: assert property (@(negedge clk_in) disable iff (!rst_n)
        $rose(late_pulse) |-> !early_pulse);
endmodule

// File: tb/clk_two_thirds_div_bench.sv
`timescale 1ns/1ps
// Bench for clk_two_thirds_div. A behavioural model gives the expected
// output level in both halves of every input period.
module clk_two_thirds_div_bench;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic clk_out;
    logic clk_out_n;

    real hi_t = 5.0;
    real lo_t = 5.0;

    int  tests = 0;
    int  fails = 0;
    int  k = 0;
    int  prev_k = 0;
    int  rises = 0;
    bit  timing_on = 1'b0;
    real last_rise = -1.0;
    bit  finished = 1'b0;

    clk_two_thirds_div u_clk_two_thirds_div (
        .clk_in    (clk),
        .rst_n     (rst_n),
        .clk_out   (clk_out),
        .clk_out_n (clk_out_n)
    );

    // Input clock; 100 MHz when hi_t and lo_t are both 5 ns.
    always begin
        #(lo_t) clk = 1'b1;
        #(hi_t) clk = 1'b0;
    end

    function automatic bit early_on(int n);
        return (n >= 3) && (n % 3 == 0);
    endfunction

    function automatic bit late_on(int n);
        return (n >= 4) && (n % 3 == 1);
    endfunction

    task automatic check(bit cond, string req, string what, int act, int exp);
        tests++;
        if (!cond) begin
            fails++;
            $display("FAIL %s %s: actual %0d expected %0d at %0t", req, what, act, exp, $time);
        end
    endtask

    function automatic string tag_for(int n);
        if (!rst_n) return "R1";
        if (n < 3)  return "R2";
        if (hi_t != lo_t) return "R8";
        return "R7";
    endfunction

    // One input period: update the model, then sample both halves.
    task automatic step();
        bit exp;
        @(posedge clk);
        prev_k = k;
        if (rst_n) k = k + 1;
        else       k = 0;
        #(hi_t / 2.0);
        exp = early_on(k) || late_on(prev_k);
        check(clk_out == exp, tag_for(k), "clk_out first half", clk_out, exp);
        check(clk_out_n == ~clk_out, "R6", "clk_out_n first half", clk_out_n, !clk_out);
        @(negedge clk);
        #(lo_t / 2.0);
        exp = early_on(k) || late_on(k);
        check(clk_out == exp, tag_for(k), "clk_out second half", clk_out, exp);
        check(clk_out_n == ~clk_out, "R6", "clk_out_n second half", clk_out_n, !clk_out);
    endtask

    task automatic run(int n);
        for (int i = 0; i < n; i++) step();
    endtask

    // Count output rises; check the spacing while the input is symmetric.
    always @(posedge clk_out) begin
        rises++;
        if (timing_on && last_rise >= 0.0) begin
            tests++;
            if ($realtime - last_rise < 14.99 || $realtime - last_rise > 15.01) begin
                fails++;
                $display("FAIL R5 rise spacing: actual %0f expected 15.0", $realtime - last_rise);
            end
        end
        last_rise = $realtime;
    end

    // Check the pulse width while the input is symmetric.
    always @(negedge clk_out) begin
        if (timing_on && last_rise >= 0.0) begin
            tests++;
            if ($realtime - last_rise < 9.99 || $realtime - last_rise > 10.01) begin
                fails++;
                $display("FAIL R4 pulse width: actual %0f expected 10.0", $realtime - last_rise);
            end
        end
    end

    // Main sequence.
    initial begin
        rst_n = 1'b0;
        run(4);                              // R1: outputs held low during reset
        check(clk_out == 1'b0, "R1", "reset level", clk_out, 0);
        rst_n = 1'b1;
        last_rise = -1.0;
        timing_on = 1'b1;
        run(12);                             // R2 start-up, R7 placement
        rises = 0;
        run(30);
        check(rises == 20, "R3", "rises in 30 periods", rises, 20);

        rst_n = 1'b0;                        // R1: reset mid-run
        timing_on = 1'b0;
        run(2);
        rst_n = 1'b1;
        last_rise = -1.0;
        timing_on = 1'b1;
        run(20);

        rst_n = 1'b0;                        // R8: lopsided input duty
        timing_on = 1'b0;
        hi_t = 3.0;
        lo_t = 7.0;
        run(2);
        rst_n = 1'b1;
        run(6);
        rises = 0;
        run(30);
        check(rises == 20, "R8", "rises in 30 lopsided periods", rises, 20);

        finished = 1'b1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    // Watchdog: a hung run counts as a failure.
    initial begin
        #(100000.0);
        if (!finished) begin
            tests++;
            fails++;
            $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end
endmodule